// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block controls a bank of general-purpose pins (32 by default) through a small word-addressed register bus. Each pin can be made an output or left as an input. Output levels are changed through two write-only ports. One sets every pin whose data bit is 1, and the other clears every such pin. No read-modify-write is needed, so two agents can update different pins without interfering.

Every pin can also raise an interrupt. Three per-pin configuration bits select the trigger:

- A detection-method bit chooses edge or level detection.
- A dual-edge bit makes an edge-mode pin fire on both transitions.
- A polarity bit chooses the rising or falling edge in single-edge mode, and the active-high or active-low level in level mode.

Raw status, enable, mask and a write-one acknowledge are held per pin. All pins feed one registered interrupt output. Pin inputs are synchronised by two flops before detection, and the synchronised values are readable.

Software reads the raw or masked status to find which pins fired. It then acknowledges them by writing ones.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset every register reads 0. This means all pins are inputs (`pinOutEn`=0), `pinOut`=0, all interrupts are disabled, and `irqOut`=0.
- R2: The direction register (word address 0) drives `pinOutEn` directly; a 1 bit makes the pin an output. It reads back what was written, and it changes only when it is written.
- R3: A write to the set port (address 2) drives high each pin whose data bit is 1. A write to the clear port (address 3) drives low each pin whose data bit is 1. Pins whose data bit is 0 keep their level.
- R4: The pin-state register (address 1) returns `pinIn` delayed by two clock edges.
- R5: With method bit (address 9) = 0, dual-edge bit (address 10) = 0 and polarity bit (address 11) = 0, a synchronised 0-to-1 transition sets that pin's raw status bit (address 6). The bit stays set and a 1-to-0 transition does not set it. The raw bit appears on the third rising clock edge after the pin changes.
- R6: With method 0, dual-edge 0 and polarity 1, only 1-to-0 transitions set the raw bit.
- R7: With method 0 and dual-edge 1, both transitions set the raw bit, whatever the polarity bit holds.
- R8: With method 1, the raw bit follows the active level each cycle: high when polarity is 0, low when polarity is 1. An acknowledge does not keep it clear while the level is still active.
- R9: Writing 1 to a bit of the acknowledge port (address 8) clears that edge-mode raw bit, and writing 0 leaves it unchanged. An edge detected in the same cycle as its acknowledge keeps the bit set.
- R10: Masked status (address 7) equals raw AND enable (address 4) AND NOT mask (address 5).
- R11: `irqOut` is the OR of all masked status bits, registered, so it follows the masked status one clock later.
- R12: The write-only addresses 2, 3 and 8 and the unused addresses 12 to 15 read 0. Writes to read-only or unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busAddr | input | 4 | Word address |
| busWdata | input | NUM_PINS | Write data, one bit per pin |
| busRdata | output | NUM_PINS | Combinational read data for `busAddr` |
| pinIn | input | NUM_PINS | Asynchronous pin levels from the pads |
| pinOut | output | NUM_PINS | Output levels to the pads |
| pinOutEn | output | NUM_PINS | Output enable per pin (1 = output) |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge as a new edge event on the same pin. The bench reaches it by counting the synchroniser and detection stages from the pin change, then starting the acknowledge write so that it completes exactly on the edge where the event is recorded. The other sweeps cover every pin in each of the trigger modes. A second hard case is the return to level mode after an acknowledge: the acknowledge must not stick while the level is still active, so the bench acknowledges while the pin is still held at its active level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 4'd0,
    A_PIN  = 4'd1,
    A_SET  = 4'd2,
    A_CLR  = 4'd3,
    A_EN   = 4'd4,
    A_MASK = 4'd5,
    A_RAW  = 4'd6,
    A_MSKD = 4'd7,
    A_ACK  = 4'd8,
    A_METH = 4'd9,
    A_BOTH = 4'd10,
    A_POL  = 4'd11
  } regAddr_e;

  // write strobes from control to datapath, plus the read selector
  typedef struct packed {
    logic              wrDir;
    logic              wrSet;
    logic              wrClr;
    logic              wrEn;
    logic              wrMask;
    logic              wrAck;
    logic              wrMeth;
    logic              wrBoth;
    logic              wrPol;
    logic [ADDR_W-1:0] rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = busAddr;
    if (busWrEn) begin
      case (busAddr)
        A_DIR:   strb.wrDir  = 1'b1;
        A_SET:   strb.wrSet  = 1'b1;
        A_CLR:   strb.wrClr  = 1'b1;
        A_EN:    strb.wrEn   = 1'b1;
        A_MASK:  strb.wrMask = 1'b1;
        A_ACK:   strb.wrAck  = 1'b1;
        A_METH:  strb.wrMeth = 1'b1;
        A_BOTH:  strb.wrBoth = 1'b1;
        A_POL:   strb.wrPol  = 1'b1;
        default: ;
      endcase
    end
  end

  logic [8:0] wrVec;
  assign wrVec = {strb.wrDir, strb.wrSet, strb.wrClr, strb.wrEn, strb.wrMask,
                  strb.wrAck, strb.wrMeth, strb.wrBoth, strb.wrPol};

  // R12: at most one register is written per cycle
  assert_one_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  // R12: no write strobe without a bus write
  assert_no_stray_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> (wrVec == '0));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);

  localparam logic [NUM_PINS-1:0] ALL_ZERO = '0;

  logic [NUM_PINS-1:0] dirQ, outQ, enQ, maskQ, methQ, bothQ, polQ;
  logic [NUM_PINS-1:0] syncA, syncB, prevQ, rawQ, rawNext;
  logic [NUM_PINS-1:0] ackBits, maskedSt;
  logic                irqQ;

  assign ackBits  = strb.wrAck ? busWdata : ALL_ZERO;
  assign maskedSt = rawQ & enQ & ~maskQ;

  // per-pin trigger evaluation
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic riseEv, fallEv, edgeHit, lvlAct;
    assign riseEv  = syncB[p] & ~prevQ[p];
    assign fallEv  = ~syncB[p] & prevQ[p];
    assign lvlAct  = syncB[p] ^ polQ[p];
    assign edgeHit = bothQ[p] ? (riseEv | fallEv)
                              : (polQ[p] ? fallEv : riseEv);
    assign rawNext[p] = methQ[p] ? lvlAct
                                 : (edgeHit | (rawQ[p] & ~ackBits[p]));
  end

  // input synchroniser and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  // configuration and output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ  <= '0;
      outQ  <= '0;
      enQ   <= '0;
      maskQ <= '0;
      methQ <= '0;
      bothQ <= '0;
      polQ  <= '0;
    end else begin
      if (strb.wrDir)  dirQ  <= busWdata;
      if (strb.wrEn)   enQ   <= busWdata;
      if (strb.wrMask) maskQ <= busWdata;
      if (strb.wrMeth) methQ <= busWdata;
      if (strb.wrBoth) bothQ <= busWdata;
      if (strb.wrPol)  polQ  <= busWdata;
      if (strb.wrSet)      outQ <= outQ | busWdata;
      else if (strb.wrClr) outQ <= outQ & ~busWdata;
    end
  end

  // status and combined interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ <= '0;
      irqQ <= 1'b0;
    end else begin
      rawQ <= rawNext;
      irqQ <= |maskedSt;
    end
  end

  assign pinOut   = outQ;
  assign pinOutEn = dirQ;
  assign irqOut   = irqQ;

  always_comb begin
    case (strb.rdSel)
      A_DIR:   busRdata = dirQ;
      A_PIN:   busRdata = syncB;
      A_EN:    busRdata = enQ;
      A_MASK:  busRdata = maskQ;
      A_RAW:   busRdata = rawQ;
      A_MSKD:  busRdata = maskedSt;
      A_METH:  busRdata = methQ;
      A_BOTH:  busRdata = bothQ;
      A_POL:   busRdata = polQ;
      default: busRdata = '0;
    endcase
  end

  // R3: set port raises every selected pin
  assert_set_pins_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((pinOut & $past(busWdata)) == $past(busWdata)));

  // R3: clear port lowers every selected pin
  assert_clr_pins_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((pinOut & $past(busWdata)) == ALL_ZERO));

  // R2: output enables move only on a direction write
  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(pinOutEn));

  // R9: a latched edge-mode status bit survives until acknowledged
  assert_edge_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rawQ) & ~$past(methQ) & ~$past(ackBits) & ~rawQ) == ALL_ZERO));

  // R11: no interrupt one cycle after all enables are off
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == ALL_ZERO) |=> !irqOut);

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);

  ctrlStrobe_t strb;

  gpio_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/gpio_irq_top_test.sv
`timescale 1ns/1ps
module gpio_irq_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOutEn;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_top uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; the register updates on the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, expOut;
    waitN(4);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v); chk("R1 reset readback", v, 32'h0);
    end
    chk("R1 pinOut", pinOut, 0);
    chk("R1 pinOutEn", pinOutEn, 0);
    chk("R1 irqOut", {31'b0, irqOut}, 0);

    // R2 direction
    for (int k = 0; k < 32; k++) begin
      wr(4'd0, 32'h1 << k);
      rd(4'd0, v); chk("R2 dir readback", v, 32'h1 << k);
      chk("R2 pinOutEn", pinOutEn, 32'h1 << k);
    end
    wr(4'd0, 32'hA5C3_0F96);
    waitN(3);
    chk("R2 pinOutEn hold", pinOutEn, 32'hA5C3_0F96);

    // R3 set and clear
    expOut = '0;
    for (int k = 0; k < 40; k++) begin
      v = 32'h9E37_79B9 * (k + 1);
      if (k % 2 == 0) begin wr(4'd2, v); expOut = expOut | v; end
      else            begin wr(4'd3, v); expOut = expOut & ~v; end
      chk("R3 pinOut", pinOut, expOut);
    end
    wr(4'd2, 32'h0); chk("R3 set zero keeps", pinOut, expOut);
    wr(4'd3, 32'h0); chk("R3 clear zero keeps", pinOut, expOut);

    // R12 write-only and unused reads, ignored writes
    foreach (v[i]) ;
    for (int a = 12; a < 16; a++) wr(a[3:0], 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R12 set reads 0", v, 0);
    rd(4'd3, v); chk("R12 clear reads 0", v, 0);
    rd(4'd8, v); chk("R12 ack reads 0", v, 0);
    for (int a = 12; a < 16; a++) begin
      rd(a[3:0], v); chk("R12 unused reads 0", v, 0);
    end
    rd(4'd0, v); chk("R12 dir untouched", v, 32'hA5C3_0F96);
    rd(4'd4, v); chk("R12 enable untouched", v, 0);
    rd(4'd6, v); chk("R12 raw untouched", v, 0);
    chk("R12 pinOut untouched", pinOut, expOut);

    // R4 input synchroniser latency
    pinIn = 32'h0F0F_1234;
    waitN(1); rd(4'd1, v); chk("R4 one edge old", v, 32'h0);
    waitN(1); rd(4'd1, v); chk("R4 two edges new", v, 32'h0F0F_1234);
    pinIn = 32'hFFFF_0000;
    waitN(1); rd(4'd1, v); chk("R4 one edge old", v, 32'h0F0F_1234);
    waitN(1); rd(4'd1, v); chk("R4 two edges new", v, 32'hFFFF_0000);
    pinIn = '0;
    waitN(4);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);
    waitN(1);

    // R5 R6 R7 edge modes over every pin; R11 latency
    for (int m = 0; m < 4; m++) begin
      logic riseOn, fallOn;
      case (m)
        0: begin wr(4'd10, 0); wr(4'd11, 0); riseOn = 1; fallOn = 0; end
        1: begin wr(4'd10, 0); wr(4'd11, 32'hFFFF_FFFF); riseOn = 0; fallOn = 1; end
        2: begin wr(4'd10, 32'hFFFF_FFFF); wr(4'd11, 0); riseOn = 1; fallOn = 1; end
        default: begin wr(4'd10, 32'hFFFF_FFFF); wr(4'd11, 32'hFFFF_FFFF); riseOn = 1; fallOn = 1; end
      endcase
      for (int p = 0; p < 32; p++) begin
        logic [31:0] b;
        b = 32'h1 << p;
        pinIn = b;
        waitN(3);
        rd(4'd6, v);
        chk(m == 1 ? "R6 rise ignored" : (m == 0 ? "R5 rise sets" : "R7 rise sets"),
            v, riseOn ? b : 32'h0);
        chk("R11 irq not yet", {31'b0, irqOut}, 0);
        waitN(1);
        chk("R11 irq one cycle later", {31'b0, irqOut}, {31'b0, riseOn});
        pinIn = '0;
        waitN(3);
        rd(4'd6, v);
        chk(m == 0 ? "R5 sticky, fall ignored" : (m == 1 ? "R6 fall sets" : "R7 fall sets"),
            v, (riseOn | fallOn) ? b : 32'h0);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd6, v); chk("R9 ack clears", v, 0);
        waitN(1);
        chk("R11 irq drops", {31'b0, irqOut}, 0);
      end
    end

    // R9 ack of zero, and ack colliding with a new edge
    wr(4'd10, 0); wr(4'd11, 0);
    pinIn = 32'h20; waitN(3);
    wr(4'd8, 32'h0);
    rd(4'd6, v); chk("R9 ack zero keeps", v, 32'h20);
    pinIn = 0; waitN(3);
    pinIn = 32'h20; waitN(2);
    wr(4'd8, 32'h20);
    rd(4'd6, v); chk("R9 event wins over same-cycle ack", v, 32'h20);
    wr(4'd8, 32'h20);
    rd(4'd6, v); chk("R9 later ack clears", v, 0);
    pinIn = 0; waitN(3);
    pinIn = 32'h20; waitN(3);

    // R10 masking of raw bit 5
    wr(4'd4, 32'h20); wr(4'd5, 0);
    rd(4'd7, v); chk("R10 masked enabled", v, 32'h20);
    waitN(1); chk("R11 irq on", {31'b0, irqOut}, 1);
    wr(4'd5, 32'h20);
    rd(4'd7, v); chk("R10 masked by mask", v, 0);
    waitN(1); chk("R11 irq off masked", {31'b0, irqOut}, 0);
    wr(4'd5, 0); wr(4'd4, 32'hFFFF_FFDF);
    rd(4'd7, v); chk("R10 masked disabled", v, 0);
    rd(4'd6, v); chk("R10 raw unaffected", v, 32'h20);
    wr(4'd4, 32'hFFFF_FFFF);
    pinIn = 0; waitN(3);
    wr(4'd8, 32'hFFFF_FFFF);

    // R8 level modes
    wr(4'd11, 0); wr(4'd9, 32'hFFFF_FFFF);
    waitN(1);
    rd(4'd6, v); chk("R8 high level idle", v, 0);
    for (int p = 0; p < 32; p++) begin
      logic [31:0] b;
      b = 32'h1 << p;
      pinIn = b; waitN(3);
      rd(4'd6, v); chk("R8 high level follows", v, b);
      wr(4'd8, b);
      rd(4'd6, v); chk("R8 ack does not stick", v, b);
      pinIn = 0; waitN(3);
      rd(4'd6, v); chk("R8 level gone", v, 0);
    end
    wr(4'd11, 32'hFFFF_FFFF); waitN(1);
    rd(4'd6, v); chk("R8 low level all active", v, 32'hFFFF_FFFF);
    for (int p = 0; p < 32; p += 3) begin
      logic [31:0] b;
      b = 32'h1 << p;
      pinIn = b; waitN(3);
      rd(4'd6, v); chk("R8 low level follows", v, ~b);
      pinIn = 0; waitN(3);
    end
    wr(4'd9, 0); wr(4'd11, 0);
    wr(4'd8, 32'hFFFF_FFFF); waitN(1);
    rd(4'd6, v); chk("R9 all cleared after return to edge", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule